// File: doc/BRIEF.md
# Memory-Resident Register Add Sequencer

This block is a small 16-bit execution sequencer whose sixteen general registers are not flip-flops inside the block. They are words in an external single-port synchronous RAM. When it is started, the sequencer fetches one instruction word from the program counter. It decodes the word as a register-to-register add. It reads the two named operand registers from RAM, adds them, and stores the sum back into the RAM word of the first (destination) register. No on-chip copy of any register survives the instruction.

Work is organised in machine cycles of exactly two clocks each. Memory machine cycles strictly alternate with internal machine cycles: FETCH (memory), DECODE (internal), RD_A (memory), SETUP (internal), RD_B (memory), ADD (internal), WR_A (memory). The state machine has nine named states. IDLE waits for `start`. The seven states above run in the order given. FIN holds `done` for one clock and returns to IDLE. The transitions are: IDLE to FETCH on `start`; each machine-cycle state to the next one at the end of its second clock; DECODE to FIN instead of RD_A when the opcode is not the add opcode; WR_A to FIN; and FIN to IDLE unconditionally.

A register n lives at byte address `REG_BASE + 2*n`. The program counter starts at `RESET_VEC` and steps by 2 after every fetch. A carry-out status and an illegal-opcode status are held on outputs between instructions.

Top module: `memreg_add_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `mem_rd`, `mem_wr`, `carry` and `illegal` are all 0 until the first accepted start.
- R2: The first instruction is fetched from address `RESET_VEC` (default 0x0000), and each later instruction is fetched from the previous fetch address plus 2. Illegal instructions are included in this count.
- R3: The instruction word holds the opcode in bits 15:8, the destination register number in bits 7:4 and the second register number in bits 3:0. Register n is read and written at address `REG_BASE + 2*n` (default base 0x0080).
- R4: With opcode 0xA0, the RAM word of the destination register receives (dst + src) mod 2^16. No other RAM word changes.
- R5: `done` is high for exactly one clock. For an add, it rises on the 14th rising edge after the edge that samples `start`.
- R6: Counting clocks 1 to 14 after the start edge, `mem_rd` is high exactly in clocks 1, 2, 5, 6, 9 and 10, and `mem_addr` is held across both clocks of each memory machine cycle. Internal machine cycles (clocks 3-4, 7-8 and 11-12) assert no strobe.
- R7: `mem_wr` is high only in clock 14, the second clock of the write-back machine cycle. It is high for one clock per add. `mem_addr` and `mem_wdata` are valid in both clocks 13 and 14, and `mem_rd` and `mem_wr` are never high together.
- R8: At completion of an add, `carry` takes the carry out of the 16-bit sum. It holds that value until the next add completes.
- R9: When bits 15:8 differ from 0xA0, no operand is read and nothing is written. `done` rises on the 4th edge after start, `illegal` becomes 1 and `carry` keeps its previous value. The next completed add clears `illegal`.
- R10: `start` is ignored in every state but IDLE, including the clock in which `done` is high. A start pulse during a run causes no second fetch.
- R11: When the destination and the second register are the same register, the stored result is twice its old value, mod 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction when idle |
| busy | output | 1 | High from the clock after start until done drops |
| done | output | 1 | One-clock completion pulse |
| illegal | output | 1 | Last completed instruction had an unknown opcode |
| carry | output | 1 | Carry out of the last completed add |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one clock after the address |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |

## Verification
The bench counts rising edges from the edge that samples `start`. It samples every output at the falling edge that follows. In each clock it compares the strobes and address with the fixed schedule: the fetch in clocks 1-2, the operand reads in clocks 5-6 and 9-10, and the write in clock 14. `done` must be seen at count 14 for an add and at count 4 for an illegal opcode. At that moment the scoreboard pops the expected item and compares the written word, the carry, the illegal flag and the whole RAM image. One falling edge after the sequencer returns to IDLE, it confirms that a start pulse given mid-run produced no further activity.

// File: rtl/regadd_pkg.sv
package regadd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_RD_A,
        ST_SETUP,
        ST_RD_B,
        ST_ADD,
        ST_WR_A,
        ST_FIN
    } seq_state_e;

    function automatic logic is_mem_cycle(input seq_state_e s);
        return (s == ST_FETCH) || (s == ST_RD_A) || (s == ST_RD_B) || (s == ST_WR_A);
    endfunction

    function automatic logic is_int_cycle(input seq_state_e s);
        return (s == ST_DECODE) || (s == ST_SETUP) || (s == ST_ADD);
    endfunction

endpackage

// File: rtl/regadd_fsm.sv
module regadd_fsm
    import regadd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       opcode_ok,
    output seq_state_e state,
    output logic       ph_second,
    output logic       busy,
    output logic       done
);

    seq_state_e state_q, state_d;
    logic       ph_q, ph_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    // next state: every machine-cycle state lasts two clocks
    always_comb begin
        state_d = state_q;
        ph_d    = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  begin ph_d = !ph_q; if (ph_q) state_d = ST_DECODE; end
            ST_DECODE: begin
                ph_d = !ph_q;
                if (ph_q) state_d = opcode_ok ? ST_RD_A : ST_FIN;
            end
            ST_RD_A:   begin ph_d = !ph_q; if (ph_q) state_d = ST_SETUP; end
            ST_SETUP:  begin ph_d = !ph_q; if (ph_q) state_d = ST_RD_B; end
            ST_RD_B:   begin ph_d = !ph_q; if (ph_q) state_d = ST_ADD; end
            ST_ADD:    begin ph_d = !ph_q; if (ph_q) state_d = ST_WR_A; end
            ST_WR_A:   begin ph_d = !ph_q; if (ph_q) state_d = ST_FIN; end
            ST_FIN:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state     = state_q;
        ph_second = ph_q;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FIN);
    end

    // R5: each machine cycle spans two clocks
    a_r5_two_clock_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !ph_q) |=> (state_q == $past(state_q)) && ph_q);

    // R5: done is a single-clock pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: memory cycle is followed by an internal cycle (write-back ends the run)
    a_r6_mem_then_internal: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q && is_mem_cycle(state_q) && state_q != ST_WR_A) |=> is_int_cycle(state_q));

    // R6: internal cycle is followed by a memory cycle or the finish
    a_r6_internal_then_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q && is_int_cycle(state_q)) |=> (is_mem_cycle(state_q) || state_q == ST_FIN));

    // R10: start has no effect once running
    a_r10_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));

    a_r10_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != ST_FETCH || $past(state_q) == ST_FETCH));

endmodule

// File: rtl/regadd_datapath.sv
module regadd_datapath
    import regadd_pkg::*;
#(
    parameter int                  DATA_W     = 16,
    parameter int                  ADDR_W     = 16,
    parameter int                  IDX_W      = 4,
    parameter int                  OPC_W      = 8,
    parameter logic [OPC_W-1:0]    ADD_OPCODE = 8'hA0,
    parameter logic [ADDR_W-1:0]   RESET_VEC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              ph_second,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  dst_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic [DATA_W-1:0] sum,
    output logic              opcode_ok,
    output logic              carry,
    output logic              illegal
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(DATA_W / 8);

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q, opa_q, opb_q, sum_q;
    logic              cout_q, carry_q, illegal_q;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;

    assign {add_cout, add_sum} = {1'b0, opa_q} + {1'b0, opb_q};

    // instruction fields
    assign opcode_ok = (ir_q[DATA_W-1 -: OPC_W] == ADD_OPCODE);
    assign dst_idx   = ir_q[2*IDX_W-1 -: IDX_W];
    assign src_idx   = ir_q[IDX_W-1:0];

    // all captures happen on the edge that ends a machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= RESET_VEC;
            ir_q      <= '0;
            opa_q     <= '0;
            opb_q     <= '0;
            sum_q     <= '0;
            cout_q    <= 1'b0;
            carry_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else if (ph_second) begin
            unique case (state)
                ST_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + PC_STEP;
                end
                ST_DECODE: if (!opcode_ok) illegal_q <= 1'b1;
                ST_RD_A:   opa_q <= mem_rdata;
                ST_RD_B:   opb_q <= mem_rdata;
                ST_ADD: begin
                    sum_q  <= add_sum;
                    cout_q <= add_cout;
                end
                ST_WR_A: begin
                    carry_q   <= cout_q;
                    illegal_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign pc      = pc_q;
    assign sum     = sum_q;
    assign carry   = carry_q;
    assign illegal = illegal_q;

    // R2: program counter steps by one word per fetch
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && ph_second) |=> (pc_q == $past(pc_q) + PC_STEP));

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_FETCH && ph_second) |=> $stable(pc_q));

    // R8: carry only moves when a write-back finishes
    a_r8_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_WR_A && ph_second) |=> $stable(carry_q));

endmodule

// File: rtl/regadd_memif.sv
module regadd_memif
    import regadd_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 16,
    parameter int                IDX_W    = 4,
    parameter logic [ADDR_W-1:0] REG_BASE = 16'h0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              ph_second,
    input  logic [ADDR_W-1:0] pc,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] sum,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr
);

    localparam int N_PORTS = 2;

    logic [IDX_W-1:0]  idx_sel  [N_PORTS];
    logic [ADDR_W-1:0] reg_addr [N_PORTS];

    assign idx_sel[0] = dst_idx;
    assign idx_sel[1] = src_idx;

    // one word-address generator per operand
    for (genvar g = 0; g < N_PORTS; g++) begin : g_regaddr
        assign reg_addr[g] = REG_BASE + (ADDR_W'(idx_sel[g]) << 1);
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        unique case (state)
            ST_FETCH: begin mem_addr = pc;          mem_rd = 1'b1; end
            ST_RD_A:  begin mem_addr = reg_addr[0]; mem_rd = 1'b1; end
            ST_RD_B:  begin mem_addr = reg_addr[1]; mem_rd = 1'b1; end
            ST_WR_A: begin
                mem_addr  = reg_addr[0];
                mem_wdata = sum;
                mem_wr    = ph_second;
            end
            default: ;
        endcase
    end

    // R7: read and write never together
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: write strobe lasts one clock
    a_r7_wr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R7: write address and data were already set up in the first clock
    a_r7_wr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R6: read address held through both clocks
    a_r6_rd_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !ph_second) |=> (mem_rd && $stable(mem_addr)));

endmodule

// File: rtl/memreg_add_seq.sv
module memreg_add_seq
    import regadd_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                ADDR_W     = 16,
    parameter int                IDX_W      = 4,
    parameter int                OPC_W      = 8,
    parameter logic [OPC_W-1:0]  ADD_OPCODE = 8'hA0,
    parameter logic [ADDR_W-1:0] RESET_VEC  = 16'h0000,
    parameter logic [ADDR_W-1:0] REG_BASE   = 16'h0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              carry,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr
);

    seq_state_e        state;
    logic              ph_second;
    logic              opcode_ok;
    logic [ADDR_W-1:0] pc;
    logic [IDX_W-1:0]  dst_idx, src_idx;
    logic [DATA_W-1:0] sum;

    regadd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode_ok (opcode_ok),
        .state     (state),
        .ph_second (ph_second),
        .busy      (busy),
        .done      (done)
    );

    regadd_datapath #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .OPC_W      (OPC_W),
        .ADD_OPCODE (ADD_OPCODE),
        .RESET_VEC  (RESET_VEC)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .ph_second (ph_second),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .dst_idx   (dst_idx),
        .src_idx   (src_idx),
        .sum       (sum),
        .opcode_ok (opcode_ok),
        .carry     (carry),
        .illegal   (illegal)
    );

    regadd_memif #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .REG_BASE (REG_BASE)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .ph_second (ph_second),
        .pc        (pc),
        .dst_idx   (dst_idx),
        .src_idx   (src_idx),
        .sum       (sum),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    // R9: an unknown opcode finishes without any operand traffic
    a_r9_no_operand_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!$past(mem_rd) && !$past(mem_wr)));

endmodule

// File: tb/memreg_add_seq_tb.sv
module memreg_add_seq_tb;

    localparam logic [15:0] BASE = 16'h0080;
    localparam logic [7:0]  OPC  = 8'hA0;

    typedef struct {
        logic        illegal;
        logic [15:0] pc;
        logic [15:0] da;
        logic [15:0] sa;
        logic [15:0] wdata;
        logic        carry;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, illegal, carry, mem_rd, mem_wr;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [15:0] mem     [0:255];
    logic [15:0] exp_mem [0:255];
    exp_t        exp_q[$];
    exp_t        cur;

    int    checks = 0;
    int    errors = 0;
    int    completed = 0;
    int    cnt = 0;
    logic  tracking = 1'b0;
    int    wr_count = 0;
    logic [15:0] last_waddr = '0, last_wdata = '0;
    int    rd_err = 0, wr_err = 0, pc_err = 0, addr_err = 0;
    logic [15:0] pc_model = 16'h0000;
    logic        carry_model = 1'b0;

    always #10 clk = !clk;   // 50 MHz

    memreg_add_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .carry     (carry),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // RAM model and start-relative clock counter
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[8:1]];
        if (mem_wr) begin
            mem[mem_addr[8:1]] <= mem_wdata;
            wr_count   <= wr_count + 1;
            last_waddr <= mem_addr;
            last_wdata <= mem_wdata;
        end
        if (!rst_n) begin
            tracking <= 1'b0;
            cnt      <= 0;
        end else if (start && !busy) begin
            tracking <= 1'b1;
            cnt      <= 0;
            wr_count <= 0;
        end else if (tracking) begin
            cnt <= cnt + 1;
            if (done) tracking <= 1'b0;
        end
    end

    // monitor: per-clock schedule and completion scoreboard
    always @(negedge clk) begin
        if (rst_n && tracking && exp_q.size() > 0) begin
            cur = exp_q[0];
            if (cnt < (cur.illegal ? 4 : 14)) begin
                if (mem_rd !== (cur.illegal ? (cnt <= 1)
                                : (cnt == 0 || cnt == 1 || cnt == 4 || cnt == 5 || cnt == 8 || cnt == 9)))
                    rd_err++;
                if (mem_wr !== (!cur.illegal && cnt == 13)) wr_err++;
                if ((cnt == 0 || cnt == 1) && mem_addr !== cur.pc) pc_err++;
                if (!cur.illegal) begin
                    if ((cnt == 4 || cnt == 5 || cnt == 12 || cnt == 13) && mem_addr !== cur.da) addr_err++;
                    if ((cnt == 8 || cnt == 9) && mem_addr !== cur.sa) addr_err++;
                    if (cnt == 13 && mem_wdata !== cur.wdata) wr_err++;
                end
            end
            if (done) begin
                int bad;
                bad = 0;
                void'(exp_q.pop_front());
                chk(cnt == (cur.illegal ? 4 : 14), cur.illegal ? "R9" : "R5",
                    "done latency", cnt, cur.illegal ? 4 : 14);
                chk(rd_err == 0, "R6", "read strobe schedule", rd_err, 0);
                chk(wr_err == 0, "R7", "write strobe/data in clock 14", wr_err, 0);
                chk(pc_err == 0, "R2", "fetch address", pc_err, 0);
                chk(addr_err == 0, "R3", "operand addresses", addr_err, 0);
                chk(illegal === cur.illegal, "R9", "illegal flag", illegal, cur.illegal);
                chk(carry === cur.carry, cur.illegal ? "R9" : "R8", "carry", carry, cur.carry);
                chk(wr_count == (cur.illegal ? 0 : 1), "R7", "write count", wr_count,
                    cur.illegal ? 0 : 1);
                if (!cur.illegal)
                    chk(last_waddr === cur.da && last_wdata === cur.wdata, "R4",
                        "written word", {last_waddr, last_wdata}, {cur.da, cur.wdata});
                for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
                chk(bad == 0, "R4", "RAM image mismatches", bad, 0);
                rd_err = 0; wr_err = 0; pc_err = 0; addr_err = 0;
                completed++;
            end
        end
    end

    // driver: preload operands, push expectation, pulse start
    task automatic issue(input logic [7:0] opc, input int d, input int s,
                         input logic [15:0] va, input logic [15:0] vb, input int extra);
        exp_t e;
        logic [16:0] full;
        int target;
        int i;
        mem[pc_model[8:1]]     = {opc, 4'(d), 4'(s)};
        exp_mem[pc_model[8:1]] = {opc, 4'(d), 4'(s)};
        mem[BASE[8:1] + s] = vb;  exp_mem[BASE[8:1] + s] = vb;
        mem[BASE[8:1] + d] = va;  exp_mem[BASE[8:1] + d] = va;
        full = {1'b0, exp_mem[BASE[8:1] + d]} + {1'b0, exp_mem[BASE[8:1] + s]};
        e.illegal = (opc != OPC);
        e.pc      = pc_model;
        e.da      = BASE + 16'(2 * d);
        e.sa      = BASE + 16'(2 * s);
        e.wdata   = full[15:0];
        if (!e.illegal) begin
            carry_model = full[16];
            exp_mem[BASE[8:1] + d] = full[15:0];
        end
        e.carry = carry_model;
        exp_q.push_back(e);
        pc_model = pc_model + 16'd2;
        target = completed + 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        i = 1;
        forever begin
            start = (i == extra);
            if (completed >= target && i > extra) break;
            @(negedge clk);
            i++;
        end
        start = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr && exp_q.size() == 0, "R10",
            "idle after completion, no extra run", {busy, mem_rd, mem_wr}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 16'(i * 16'h0101);
            exp_mem[i] = 16'(i * 16'h0101);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "outputs in reset",
            {busy, done, mem_rd, mem_wr}, 0);
        chk(!carry && !illegal, "R1", "status in reset", {carry, illegal}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr && !carry && !illegal, "R1",
            "idle after reset", {busy, done, mem_rd, mem_wr, carry, illegal}, 0);

        issue(OPC, 1, 2, 16'h1234, 16'h0101, 0);    // R4 plain add
        issue(OPC, 3, 4, 16'hFFFF, 16'h0002, 0);    // R8 carry out
        issue(OPC, 15, 0, 16'h7FFF, 16'h0001, 0);   // R3 highest/lowest register
        issue(OPC, 7, 7, 16'h4000, 16'h4000, 0);    // R11 same register
        issue(OPC, 5, 6, 16'h8000, 16'h8000, 0);    // R8 zero sum with carry
        issue(8'h12, 2, 3, 16'h0001, 16'h0001, 0);  // R9 unknown opcode, carry kept
        issue(OPC, 9, 10, 16'h0001, 16'h0002, 5);   // R10 start mid-run, clears R9 flag
        issue(OPC, 12, 13, 16'hAAAA, 16'h5555, 15); // R10 start in done clock
        issue(8'hA1, 4, 5, 16'h0003, 16'h0004, 3);  // R9 neighbouring opcode, R10
        issue(OPC, 0, 15, 16'hFFFF, 16'hFFFF, 0);   // R4 max operands
        issue(OPC, 11, 11, 16'h9001, 16'h9001, 0);  // R11 doubling with carry

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule